// File: doc/BRIEF.md
# Bus Ownership Handoff Sequencer

This block decides which board drives a shared multi-master backplane, and it changes the owner in small ordered steps so that no bus line ever floats. The drivers for the control strobes and the drivers for address, data and status are switched separately, one bus clock apart. While ownership passes, the outgoing owner and the incoming owner both drive the control strobes for one clock.

In master mode the board owns the bus from reset. An active-low hold request from the backplane is synchronized and passed to the CPU as HOLD. When the CPU grants with HOLDA, the block acknowledges on the backplane. It then turns off its address/data/status drivers and, one clock after that, its control drivers. In slave mode the board starts with every driver off and its CPU held in reset. It asks for the bus when any DMA request line goes low, or when a read hits one of two local IO port addresses. It then turns on its control drivers, then its address/data/status drivers, and finally lets the CPU run. A second read of a port address gives the bus back in the reverse order. While it is the active slave, a third controller can take the bus from it through a spare request/acknowledge pair. That release uses the same two-phase sequence as master mode.

Top module: `bus_handoff_seq`

## Requirements
- R1: After reset in master mode (mode input 0 during reset), both driver enables are 1, CPU reset is 0, the backplane request output is 1 (idle), and both acknowledges and CPU HOLD are 0.
- R2: CPU HOLD goes to 1 exactly two clock edges after the active-low backplane hold request is driven to 0, and goes back to 0 two edges after the request is released.
- R3: In master mode, with HOLD asserted, the first edge that sees HOLDA at 1 sets the backplane acknowledge. The next edge clears the address/data/status enable. The edge after that clears the control enable.
- R4: When HOLDA returns to 0, the steps run in reverse, one per edge: the control enable comes on, then the address/data/status enable, then the acknowledge clears.
- R5: After reset in slave mode (mode input 1 during reset), both driver enables are 0, CPU reset is 1, and the backplane request output is 1.
- R6: In slave mode, driving any of the four active-low DMA lines to 0 makes these changes, one per edge. On the third edge the backplane request output goes to 0 and the control enable goes to 1 together. On the fourth edge the address/data/status enable goes to 1. On the fifth edge CPU reset goes to 0.
- R7: When the slave's activation is withdrawn, the exact reverse order follows, one step per edge. CPU reset goes to 1 first, then the address/data/status enable clears. Last, the control enable clears and the backplane request output returns to 1 in the same edge.
- R8: In slave mode, a read strobe whose address is 8'hED or 8'hDD toggles activation exactly once per strobe, however long the strobe lasts. Activation then proceeds one edge later than on the DMA path. A read of any other address has no effect.
- R9: While the slave fully owns the bus, the active-low secondary request reaches CPU HOLD after two edges. HOLDA then drives the secondary acknowledge and the same two-phase driver release as R3. Throughout, the backplane request stays 0, CPU reset stays 0, and the backplane acknowledge stays 0.
- R10: The secondary request has no effect while the slave does not own the bus. CPU HOLD stays 0.
- R11: In master mode the DMA lines and port reads are ignored. Drivers stay enabled and the backplane request output stays 1.
- R12: Once granted, ownership in either direction holds for as long as the request or grant persists, with no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode_i | input | 1 | Mode, sampled during reset: 1 = slave, 0 = master |
| bp_hold_req_n_i | input | 1 | Backplane hold request to this master, active low |
| bp_hold_ack_o | output | 1 | Backplane hold acknowledge from this master |
| dma_req_n_i | input | 4 | Slave activation lines, active low |
| io_rd_i | input | 1 | Local IO read strobe |
| io_addr_i | input | 8 | Local IO read address |
| bp_hold_req_n_o | output | 1 | Slave's request for the backplane, active low |
| sec_req_n_i | input | 1 | Secondary request from a third controller, active low |
| sec_ack_o | output | 1 | Secondary acknowledge |
| cpu_hold_o | output | 1 | HOLD to the CPU |
| cpu_holda_i | input | 1 | HOLDA from the CPU |
| cpu_reset_o | output | 1 | CPU reset, active high |
| ctl_drv_en_o | output | 1 | Enable for the control-strobe drivers |
| adr_drv_en_o | output | 1 | Enable for the address, data and status drivers |

## Verification
The bench checks the exact edge at which each driver enable changes, in both directions and in both modes. A design that switched both driver groups together, or in the wrong order, would leave the control lines floating, and the bench would see the wrong enable pattern at that edge. It holds a port-read strobe high for many cycles and then waits. A level-sensitive toggle would flip activation on and off and lose the bus. It raises the secondary request while the slave is idle, and it applies DMA and port stimulus in master mode. A design that did not gate these inputs would assert HOLD, or drop its drivers, while no handoff was in progress.

// File: rtl/hs_pkg.sv
package hs_pkg;
   // Ownership ladder: each step up enables one more stage of the handoff.
   typedef logic [1:0] lvl_t;
   localparam lvl_t LVL_NONE = 2'd0;
   localparam lvl_t LVL_CTL  = 2'd1;
   localparam lvl_t LVL_ADR  = 2'd2;
   localparam lvl_t LVL_FULL = 2'd3;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] st [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("hs_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("hs_sync: W must be at least 1");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[g] <= '0;
            else        st[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[g] <= '0;
            else        st[g] <= st[g-1];
         end
      end
   end

   assign q_o = st[STAGES-1];
endmodule

// File: rtl/hs_ladder.sv
module hs_ladder
   import hs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  lvl_t rst_lvl_i,
   input  logic up_i,
   input  logic freeze_i,
   output lvl_t lvl_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_o <= rst_lvl_i;
      end else if (!freeze_i) begin
         if (up_i && lvl_o != LVL_FULL)
            lvl_o <= lvl_o + 2'd1;
         else if (!up_i && lvl_o != LVL_NONE)
            lvl_o <= lvl_o - 2'd1;
      end
   end
endmodule

// File: rtl/hs_port_toggle.sv
module hs_port_toggle #(
   parameter int unsigned          ADDR_W = 8,
   parameter logic [ADDR_W-1:0]    PORT_A = 8'hED,
   parameter logic [ADDR_W-1:0]    PORT_B = 8'hDD,
   parameter int unsigned          STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              flag_o
);
   logic hit, hit_s, hit_prev, hit_rise;

   assign hit = rd_i && (addr_i == PORT_A || addr_i == PORT_B);

   hs_sync #(.W(1), .STAGES(STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(hit), .q_o(hit_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_prev <= 1'b0;
      else        hit_prev <= hit_s;
   end

   assign hit_rise = hit_s && !hit_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag_o <= 1'b0;
      else if (en_i && hit_rise) flag_o <= !flag_o;
   end
endmodule

// File: rtl/bus_handoff_seq.sv
module bus_handoff_seq
   import hs_pkg::*;
#(
   parameter int unsigned       N_DMA       = 4,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter int unsigned       ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] PORT_A      = 8'hED,
   parameter logic [ADDR_W-1:0] PORT_B      = 8'hDD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slave_mode_i,
   input  logic              bp_hold_req_n_i,
   output logic              bp_hold_ack_o,
   input  logic [N_DMA-1:0]  dma_req_n_i,
   input  logic              io_rd_i,
   input  logic [ADDR_W-1:0] io_addr_i,
   output logic              bp_hold_req_n_o,
   input  logic              sec_req_n_i,
   output logic              sec_ack_o,
   output logic              cpu_hold_o,
   input  logic              cpu_holda_i,
   output logic              cpu_reset_o,
   output logic              ctl_drv_en_o,
   output logic              adr_drv_en_o
);
   localparam int unsigned SW = N_DMA + 2;

   if (N_DMA < 1) begin : g_bad_dma
      $error("bus_handoff_seq: N_DMA must be at least 1");
   end

   logic          slave_q;
   logic [SW-1:0] req_s;
   logic [N_DMA-1:0] dma_s;
   logic          hold_s, sec_s, dma_any, port_flag, want;
   lvl_t          own, yld;
   logic          own_freeze, yld_freeze;

   // Mode is captured while reset is applied and kept afterwards.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slave_q <= slave_mode_i;
      else        slave_q <= slave_q;
   end

   hs_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_req_sync (
      .clk(clk), .rst_n(rst_n),
      .d_i({~sec_req_n_i, ~bp_hold_req_n_i, ~dma_req_n_i}),
      .q_o(req_s)
   );

   assign dma_s  = req_s[N_DMA-1:0];
   assign hold_s = req_s[N_DMA];
   assign sec_s  = req_s[N_DMA+1];

   if (N_DMA == 1) begin : g_dma_single
      assign dma_any = dma_s[0];
   end else begin : g_dma_multi
      assign dma_any = |dma_s;
   end

   hs_port_toggle #(
      .ADDR_W(ADDR_W), .PORT_A(PORT_A), .PORT_B(PORT_B), .STAGES(SYNC_STAGES)
   ) u_port (
      .clk(clk), .rst_n(rst_n), .en_i(slave_q),
      .rd_i(io_rd_i), .addr_i(io_addr_i), .flag_o(port_flag)
   );

   assign want = dma_any || port_flag;

   // Own ladder: slave acquisition (request+ctl, adr, cpu run).
   assign own_freeze = (yld != LVL_FULL);
   hs_ladder u_own (
      .clk(clk), .rst_n(rst_n),
      .rst_lvl_i(slave_mode_i ? LVL_NONE : LVL_FULL),
      .up_i(slave_q ? want : 1'b1),
      .freeze_i(own_freeze),
      .lvl_o(own)
   );

   // Yield ladder: giving the bus away on HOLDA (ack, adr off, ctl off).
   assign yld_freeze = slave_q && (own != LVL_FULL) && (yld == LVL_FULL);
   hs_ladder u_yld (
      .clk(clk), .rst_n(rst_n),
      .rst_lvl_i(LVL_FULL),
      .up_i(!cpu_holda_i),
      .freeze_i(yld_freeze),
      .lvl_o(yld)
   );

   assign ctl_drv_en_o    = (own >= LVL_CTL) && (yld >= LVL_CTL);
   assign adr_drv_en_o    = (own >= LVL_ADR) && (yld >= LVL_ADR);
   assign cpu_reset_o     = slave_q && (own != LVL_FULL);
   assign bp_hold_req_n_o = !(slave_q && (own >= LVL_CTL));
   assign bp_hold_ack_o   = !slave_q && (yld != LVL_FULL);
   assign sec_ack_o       = slave_q && (yld != LVL_FULL);
   assign cpu_hold_o      = slave_q ? (sec_s && own == LVL_FULL) : hold_s;
endmodule

// File: rtl/hs_checker.sv
module hs_checker (
   input logic clk,
   input logic rst_n,
   input logic slave_q,
   input logic cpu_holda_i,
   input logic ctl_drv_en_o,
   input logic adr_drv_en_o,
   input logic bp_hold_ack_o,
   input logic sec_ack_o,
   input logic bp_hold_req_n_o,
   input logic cpu_reset_o
);
   // R3
   adr_needs_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adr_drv_en_o |-> ctl_drv_en_o);

   // R3
   ctl_off_after_adr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctl_drv_en_o) |-> !$past(adr_drv_en_o));

   // R6
   reset_release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_reset_o) |-> ($past(adr_drv_en_o) && !$past(bp_hold_req_n_o)));

   // R3
   ack_follows_holda_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bp_hold_ack_o) |-> $past(cpu_holda_i));

   // R9
   single_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bp_hold_ack_o, sec_ack_o}));

   // R6
   slave_req_with_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slave_q && !sec_ack_o) |-> (ctl_drv_en_o == !bp_hold_req_n_o));

   // R11
   master_no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !slave_q |-> (bp_hold_req_n_o && !cpu_reset_o));
endmodule

bind bus_handoff_seq hs_checker u_hs_chk (
   .clk(clk),
   .rst_n(rst_n),
   .slave_q(slave_q),
   .cpu_holda_i(cpu_holda_i),
   .ctl_drv_en_o(ctl_drv_en_o),
   .adr_drv_en_o(adr_drv_en_o),
   .bp_hold_ack_o(bp_hold_ack_o),
   .sec_ack_o(sec_ack_o),
   .bp_hold_req_n_o(bp_hold_req_n_o),
   .cpu_reset_o(cpu_reset_o)
);

// File: tb/bus_handoff_seq_bench.sv
module bus_handoff_seq_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic slave_mode = 1'b0;
   logic bp_req_n = 1'b1;
   logic [3:0] dma_n = 4'hF;
   logic io_rd = 1'b0;
   logic [7:0] io_addr = 8'h00;
   logic sec_req_n = 1'b1;
   logic holda = 1'b0;
   logic bp_ack, bp_req_n_o, sec_ack, cpu_hold, cpu_reset, ctl_en, adr_en;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_handoff_seq u_bus_handoff_seq (
      .clk(clk), .rst_n(rst_n), .slave_mode_i(slave_mode),
      .bp_hold_req_n_i(bp_req_n), .bp_hold_ack_o(bp_ack),
      .dma_req_n_i(dma_n), .io_rd_i(io_rd), .io_addr_i(io_addr),
      .bp_hold_req_n_o(bp_req_n_o), .sec_req_n_i(sec_req_n),
      .sec_ack_o(sec_ack), .cpu_hold_o(cpu_hold), .cpu_holda_i(holda),
      .cpu_reset_o(cpu_reset), .ctl_drv_en_o(ctl_en), .adr_drv_en_o(adr_en)
   );

   // Observed vector: {hold, bp_ack, ctl, adr, req_n_o, cpu_reset, sec_ack}
   function automatic logic [6:0] obs();
      return {cpu_hold, bp_ack, ctl_en, adr_en, bp_req_n_o, cpu_reset, sec_ack};
   endfunction

   task automatic cyc(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
      end
   endtask

   task automatic check(string req, logic [6:0] exp);
      checks++;
      if (obs() !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, obs(), exp);
      end
   endtask

   task automatic do_reset(logic mode);
      bp_req_n = 1'b1; dma_n = 4'hF; io_rd = 1'b0; io_addr = 8'h00;
      sec_req_n = 1'b1; holda = 1'b0;
      rst_n = 1'b0; slave_mode = mode;
      cyc(2);
      rst_n = 1'b1;
      #1;
   endtask

   // Master vectors: [8]=bp_req_n, [7]=holda, [6:0]=expected after one edge
   localparam logic [8:0] VEC [12] = '{
      9'b1_0_0011100,  // idle
      9'b0_0_0011100,  // request in first sync stage
      9'b0_0_1011100,  // HOLD after second edge
      9'b0_1_1111100,  // ack first
      9'b0_1_1110100,  // adr off
      9'b0_1_1100100,  // ctl off
      9'b0_1_1100100,  // held (R12)
      9'b1_1_1100100,
      9'b1_1_0100100,  // HOLD drops
      9'b1_0_0110100,  // ctl on
      9'b1_0_0111100,  // adr on
      9'b1_0_0011100   // ack clears
   };

   function automatic string vec_tag(int i);
      if (i < 3) return "R2";
      if (i == 6) return "R12";
      if (i < 7) return "R3";
      if (i == 8) return "R2";
      return "R4";
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      // R1 master reset state
      do_reset(1'b0);
      check("R1", 7'b0011100);

      foreach (VEC[i]) begin
         bp_req_n = VEC[i][8];
         holda    = VEC[i][7];
         cyc();
         check(vec_tag(i), VEC[i][6:0]);
      end

      // R11 master ignores DMA lines and port reads
      dma_n = 4'h0; io_rd = 1'b1; io_addr = 8'hED;
      cyc(10);
      check("R11", 7'b0011100);
      dma_n = 4'hF; io_rd = 1'b0;

      // R5 slave reset state
      do_reset(1'b1);
      check("R5", 7'b0000110);

      // R6 DMA activation on line 2
      dma_n = 4'b1011;
      cyc(2); check("R6", 7'b0000110);
      cyc();  check("R6", 7'b0010010);
      cyc();  check("R6", 7'b0011010);
      cyc();  check("R6", 7'b0011000);
      cyc(20); check("R12", 7'b0011000);

      // R9 secondary takeover while slave owns the bus
      sec_req_n = 1'b0;
      cyc(); check("R9", 7'b0011000);
      cyc(); check("R9", 7'b1011000);
      holda = 1'b1;
      cyc(); check("R9", 7'b1011001);
      cyc(); check("R9", 7'b1010001);
      cyc(); check("R9", 7'b1000001);
      cyc(5); check("R9", 7'b1000001);
      sec_req_n = 1'b1;
      cyc(2); check("R9", 7'b0000001);
      holda = 1'b0;
      cyc(); check("R9", 7'b0010001);
      cyc(); check("R9", 7'b0011001);
      cyc(); check("R9", 7'b0011000);

      // R7 release in reverse order
      dma_n = 4'hF;
      cyc(2); check("R7", 7'b0011000);
      cyc();  check("R7", 7'b0011010);
      cyc();  check("R7", 7'b0010010);
      cyc();  check("R7", 7'b0000110);

      // R10 secondary request ignored while not owning
      sec_req_n = 1'b0;
      cyc(4); check("R10", 7'b0000110);
      sec_req_n = 1'b1;
      cyc(3);

      // R8 long port read at EDh: exactly one toggle
      io_rd = 1'b1; io_addr = 8'hED;
      cyc(3); check("R8", 7'b0000110);
      cyc();  check("R8", 7'b0010010);
      cyc(2); check("R8", 7'b0011000);
      cyc(4);
      io_rd = 1'b0;
      cyc(10); check("R8", 7'b0011000);

      // R8 one-cycle read at DDh gives the bus back
      io_rd = 1'b1; io_addr = 8'hDD;
      cyc();
      io_rd = 1'b0;
      cyc(5); check("R8", 7'b0000110);

      // R8 other address ignored
      io_rd = 1'b1; io_addr = 8'h3C;
      cyc(2);
      io_rd = 1'b0;
      cyc(8); check("R8", 7'b0000110);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule